// File: doc/BRIEF.md
# Sixteen-bit ALU with Status Flags

This block is the execute stage arithmetic unit of a small 16-bit microcontroller core. Each clock it takes a source operand, a destination operand, a 4-bit operation code, a byte/word select and the current status flags. One cycle later it presents the result, a destination write enable, the updated flag vector and a branch-taken decision.

The unit covers the two-operand operations: move, add, add with carry, subtract, subtract with carry, compare, packed-BCD add, bit test, bit clear, bit set, exclusive-or and and. It also covers the single-operand data operations: rotate right through carry, arithmetic shift right, byte swap and sign extend. Subtraction is done as destination plus the inverted source plus a carry-in, so the carry flag means "no borrow". A separate 3-bit condition field is evaluated against the incoming flags for conditional jumps.

Top module: `aluFlagUnit`

## Requirements
- R1: Operation codes are 0 rotate-through-carry, 1 byte swap, 2 arithmetic shift right, 3 sign extend, 4 move, 5 add, 6 add-with-carry, 7 subtract-with-carry, 8 subtract, 9 compare, 10 decimal add, 11 bit test, 12 bit clear, 13 bit set, 14 xor, 15 and. Inputs sampled at a clock edge appear on the outputs after that edge. While reset is low, all outputs read zero.
- R2: Add gives dst+src and add-with-carry gives dst+src+C. Subtract and compare give dst+~src+1, and subtract-with-carry gives dst+~src+C. For all of these, C is the carry out of the active width and V is signed overflow of that sum.
- R3: Decimal add treats both operands as packed 4-bit BCD digits and adds src+dst+C digit by digit. Any digit sum above 9 is corrected by adding 6 and carries into the next digit. C is the carry out of the top active digit and V is 0.
- R4: Move passes src. And and bit test give src&dst, bit clear gives ~src&dst, bit set gives src|dst, and xor gives src^dst. For and, bit test and xor, C is 1 when the result is nonzero. V is 0 for and and bit test, and for xor V is 1 when both operand sign bits are 1.
- R5: Compare and bit test drive the write enable low, but the result port still carries the difference or the and. Every other operation drives the write enable high.
- R6: Arithmetic shift right keeps the sign bit and rotate-through-carry moves C into the sign bit. Both shift the destination right by one, set C to its old bit 0 and clear V.
- R7: Byte swap exchanges the two bytes of the destination. Sign extend copies destination bit 7 into bits 15..8. Both always work on the full word, whatever the byte select says. Sign extend sets flags like and.
- R8: Move, bit clear, bit set and byte swap return the incoming flag vector unchanged.
- R9: With byte select high, operations other than byte swap and sign extend use only the low bytes of the operands and output zero in result bits 15..8. N, C and V then come from bit 7 and Z from the low byte.
- R10: Condition codes taken against the incoming flags are: 0 Z=0, 1 Z=1, 2 C=0, 3 C=1, 4 N=1, 5 N==V, 6 N!=V, 7 always.
- R11: The flag vector bits are 0 C, 1 Z, 2 N, 3 V. For every operation that updates flags, N is the sign bit of the active-width result and Z is 1 exactly when the output result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opIn | input | 4 | Operation code |
| byteIn | input | 1 | Byte width select |
| srcIn | input | 16 | Source operand |
| dstIn | input | 16 | Destination operand |
| flagsIn | input | 4 | Current flags {V,N,Z,C} |
| condIn | input | 3 | Branch condition code |
| resultOut | output | 16 | Registered result |
| writeEnOut | output | 1 | Destination write enable |
| flagsOut | output | 4 | Updated flags {V,N,Z,C} |
| branchTakenOut | output | 1 | Branch condition satisfied |

## Verification
The bench aims at the width edges of the adder. 0x7FFF+1 and 0xFFFF+1 are applied, and 0x80+0x80 in byte mode, where taking carry or overflow from bit 15 instead of bit 7 would give wrong C and V. Equal-operand subtracts and subtract-with-carry with C clear check the inverted-source form; a design that forms the borrow the other way gives an inverted C. Decimal adds that ripple 9s across digits and out of the top digit catch a missing or misplaced correction. Rotates with C set, and sign extend in byte mode, catch a shift-in taken from the wrong place and a byte mask applied where it must not be. All eight branch codes are driven against flag patterns where N and V disagree, which catches a swapped signed test.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int FLAG_W = 4;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  typedef enum logic [3:0] {
    OP_RRC  = 4'd0,  OP_SWPB = 4'd1,  OP_RRA  = 4'd2,  OP_SXT  = 4'd3,
    OP_MOV  = 4'd4,  OP_ADD  = 4'd5,  OP_ADDC = 4'd6,  OP_SUBC = 4'd7,
    OP_SUB  = 4'd8,  OP_CMP  = 4'd9,  OP_DADD = 4'd10, OP_BIT  = 4'd11,
    OP_BIC  = 4'd12, OP_BIS  = 4'd13, OP_XOR  = 4'd14, OP_AND  = 4'd15
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_ADD, RS_DEC, RS_AND, RS_CLR, RS_SET, RS_XOR,
    RS_MOV, RS_SHR, RS_SWP, RS_SXT
  } resSel_e;

  typedef enum logic [2:0] {
    FM_KEEP, FM_ARITH, FM_DEC, FM_LOGIC, FM_XOR, FM_SHIFT
  } flagMode_e;

  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } cinSel_e;

  typedef struct packed {
    resSel_e   resSel;
    flagMode_e flagMode;
    cinSel_e   cinSel;
    logic      invSrc;
    logic      rotCarry;
    logic      writeBack;
    logic      forceWord;
  } aluCtrl_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);
  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    ctrl = '{resSel: RS_MOV, flagMode: FM_KEEP, cinSel: CIN_ZERO,
             invSrc: 1'b0, rotCarry: 1'b0, writeBack: 1'b1, forceWord: 1'b0};
    case (op)
      OP_MOV:  ctrl.resSel = RS_MOV;
      OP_ADD:  begin ctrl.resSel = RS_ADD; ctrl.flagMode = FM_ARITH; end
      OP_ADDC: begin ctrl.resSel = RS_ADD; ctrl.flagMode = FM_ARITH; ctrl.cinSel = CIN_FLAG; end
      OP_SUB:  begin ctrl.resSel = RS_ADD; ctrl.flagMode = FM_ARITH; ctrl.invSrc = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_SUBC: begin ctrl.resSel = RS_ADD; ctrl.flagMode = FM_ARITH; ctrl.invSrc = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_CMP:  begin ctrl.resSel = RS_ADD; ctrl.flagMode = FM_ARITH; ctrl.invSrc = 1'b1;
                     ctrl.cinSel = CIN_ONE; ctrl.writeBack = 1'b0; end
      OP_DADD: begin ctrl.resSel = RS_DEC; ctrl.flagMode = FM_DEC; ctrl.cinSel = CIN_FLAG; end
      OP_AND:  begin ctrl.resSel = RS_AND; ctrl.flagMode = FM_LOGIC; end
      OP_BIT:  begin ctrl.resSel = RS_AND; ctrl.flagMode = FM_LOGIC; ctrl.writeBack = 1'b0; end
      OP_BIC:  ctrl.resSel = RS_CLR;
      OP_BIS:  ctrl.resSel = RS_SET;
      OP_XOR:  begin ctrl.resSel = RS_XOR; ctrl.flagMode = FM_XOR; end
      OP_RRA:  begin ctrl.resSel = RS_SHR; ctrl.flagMode = FM_SHIFT; end
      OP_RRC:  begin ctrl.resSel = RS_SHR; ctrl.flagMode = FM_SHIFT; ctrl.rotCarry = 1'b1; end
      OP_SWPB: begin ctrl.resSel = RS_SWP; ctrl.forceWord = 1'b1; end
      OP_SXT:  begin ctrl.resSel = RS_SXT; ctrl.flagMode = FM_LOGIC; ctrl.forceWord = 1'b1; end
      default: ctrl.resSel = RS_MOV;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluCtrl_t            ctrl,
  input  logic                byteMode,
  input  logic [DATA_W-1:0]   srcVal,
  input  logic [DATA_W-1:0]   dstVal,
  input  logic [FLAG_W-1:0]   flagsCur,
  output logic [DATA_W-1:0]   result,
  output logic [FLAG_W-1:0]   flagsNew
);
  localparam int HALF_W = DATA_W / 2;
  localparam int DIGITS = DATA_W / 4;
  localparam int HALF_DIGITS = HALF_W / 4;

  logic              narrow;
  logic [DATA_W-1:0] lowMask, opA, opD, opB, rawRes, shifted, decSum;
  logic [DATA_W:0]   sumWide;
  logic [DIGITS:0]   decCarry;
  logic              cinBit, addCarry, addOvf, dMsb, aMsb, bMsb, sMsb, resMsb, resZero, shiftIn;

  assign narrow  = byteMode & ~ctrl.forceWord;
  assign lowMask = narrow ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign opA     = srcVal & lowMask;
  assign opD     = dstVal & lowMask;
  assign opB     = (ctrl.invSrc ? ~opA : opA) & lowMask;

  always_comb begin
    case (ctrl.cinSel)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = flagsCur[FLAG_C];
      default:  cinBit = 1'b0;
    endcase
  end

  // binary adder shared by add, subtract and compare
  assign sumWide  = {1'b0, opD} + {1'b0, opB} + {{DATA_W{1'b0}}, cinBit};
  assign addCarry = narrow ? sumWide[HALF_W] : sumWide[DATA_W];
  assign dMsb     = narrow ? opD[HALF_W-1] : opD[DATA_W-1];
  assign aMsb     = narrow ? opA[HALF_W-1] : opA[DATA_W-1];
  assign bMsb     = narrow ? opB[HALF_W-1] : opB[DATA_W-1];
  assign sMsb     = narrow ? sumWide[HALF_W-1] : sumWide[DATA_W-1];
  assign addOvf   = (dMsb == bMsb) && (sMsb != dMsb);

  // packed BCD adder, one corrected digit per stage
  always_comb begin
    logic [4:0] digitSum;
    decCarry[0] = cinBit;
    decSum = '0;
    for (int i = 0; i < DIGITS; i++) begin
      digitSum = {1'b0, opD[4*i +: 4]} + {1'b0, opA[4*i +: 4]} + {4'd0, decCarry[i]};
      if (digitSum > 5'd9) begin
        digitSum = digitSum + 5'd6;
        decCarry[i+1] = 1'b1;
      end else begin
        decCarry[i+1] = 1'b0;
      end
      decSum[4*i +: 4] = digitSum[3:0];
    end
  end

  // right shift with sign or carry shifted into the active top bit
  always_comb begin
    shiftIn = ctrl.rotCarry ? flagsCur[FLAG_C] : dMsb;
    shifted = opD >> 1;
    if (narrow) shifted[HALF_W-1] = shiftIn;
    else        shifted[DATA_W-1] = shiftIn;
  end

  always_comb begin
    case (ctrl.resSel)
      RS_ADD:  rawRes = sumWide[DATA_W-1:0];
      RS_DEC:  rawRes = decSum;
      RS_AND:  rawRes = opA & opD;
      RS_CLR:  rawRes = ~opA & opD;
      RS_SET:  rawRes = opA | opD;
      RS_XOR:  rawRes = opA ^ opD;
      RS_SHR:  rawRes = shifted;
      RS_SWP:  rawRes = {dstVal[HALF_W-1:0], dstVal[DATA_W-1:HALF_W]};
      RS_SXT:  rawRes = {{HALF_W{dstVal[HALF_W-1]}}, dstVal[HALF_W-1:0]};
      default: rawRes = opA;
    endcase
  end

  assign result  = rawRes & lowMask;
  assign resMsb  = narrow ? result[HALF_W-1] : result[DATA_W-1];
  assign resZero = (result == '0);

  always_comb begin
    flagsNew = flagsCur;
    if (ctrl.flagMode != FM_KEEP) begin
      flagsNew[FLAG_N] = resMsb;
      flagsNew[FLAG_Z] = resZero;
      flagsNew[FLAG_V] = 1'b0;
      flagsNew[FLAG_C] = ~resZero;
      case (ctrl.flagMode)
        FM_ARITH: begin flagsNew[FLAG_C] = addCarry; flagsNew[FLAG_V] = addOvf; end
        FM_DEC:   flagsNew[FLAG_C] = narrow ? decCarry[HALF_DIGITS] : decCarry[DIGITS];
        FM_XOR:   flagsNew[FLAG_V] = aMsb & dMsb;
        FM_SHIFT: flagsNew[FLAG_C] = opD[0];
        default:  flagsNew[FLAG_C] = ~resZero;
      endcase
    end
  end
endmodule

// File: rtl/aluBranch.sv
module aluBranch
  import aluPkg::*;
(
  input  logic [2:0]        cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              taken
);
  always_comb begin
    case (cond)
      3'd0:    taken = ~flags[FLAG_Z];
      3'd1:    taken =  flags[FLAG_Z];
      3'd2:    taken = ~flags[FLAG_C];
      3'd3:    taken =  flags[FLAG_C];
      3'd4:    taken =  flags[FLAG_N];
      3'd5:    taken =  flags[FLAG_N] == flags[FLAG_V];
      3'd6:    taken =  flags[FLAG_N] != flags[FLAG_V];
      default: taken = 1'b1;
    endcase
  end
endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opIn,
  input  logic              byteIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [3:0]        flagsIn,
  input  logic [2:0]        condIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              writeEnOut,
  output logic [3:0]        flagsOut,
  output logic              branchTakenOut
);
  localparam int HALF_W = DATA_W / 2;

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] resultNext;
  logic [3:0]        flagsNext;
  logic              takenNext;

  aluCtrl u_ctrl (.opCode(opIn), .ctrl(ctrl));

  aluDatapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl(ctrl), .byteMode(byteIn), .srcVal(srcIn), .dstVal(dstIn),
    .flagsCur(flagsIn), .result(resultNext), .flagsNew(flagsNext)
  );

  aluBranch u_br (.cond(condIn), .flags(flagsIn), .taken(takenNext));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultOut      <= '0;
      writeEnOut     <= 1'b0;
      flagsOut       <= '0;
      branchTakenOut <= 1'b0;
    end else begin
      resultOut      <= resultNext;
      writeEnOut     <= ctrl.writeBack;
      flagsOut       <= flagsNext;
      branchTakenOut <= takenNext;
    end
  end

  p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opIn == OP_CMP || opIn == OP_BIT) |=> !writeEnOut);

  p_byte_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byteIn && opIn != OP_SWPB && opIn != OP_SXT) |=> (resultOut[DATA_W-1:HALF_W] == '0));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opIn == OP_MOV || opIn == OP_BIC || opIn == OP_BIS || opIn == OP_SWPB)
      |=> (flagsOut == $past(flagsIn)));

  p_zero_tracks_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(opIn == OP_MOV || opIn == OP_BIC || opIn == OP_BIS || opIn == OP_SWPB)
      |=> (flagsOut[FLAG_Z] == (resultOut == '0)));

  p_jump_always_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (condIn == 3'd7) |=> branchTakenOut);
endmodule

// File: tb/sim_aluFlagUnit.sv
`timescale 1ns/1ps
module sim_aluFlagUnit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opIn;
  logic        byteIn;
  logic [15:0] srcIn, dstIn;
  logic [3:0]  flagsIn;
  logic [2:0]  condIn;
  logic [15:0] resultOut;
  logic        writeEnOut;
  logic [3:0]  flagsOut;
  logic        branchTakenOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aluFlagUnit u0 (
    .clk(clk), .rst_n(rst_n), .opIn(opIn), .byteIn(byteIn), .srcIn(srcIn),
    .dstIn(dstIn), .flagsIn(flagsIn), .condIn(condIn), .resultOut(resultOut),
    .writeEnOut(writeEnOut), .flagsOut(flagsOut), .branchTakenOut(branchTakenOut)
  );

  function automatic string reqOf(int op, bit bm);
    if (bm && op != 1 && op != 3) return "R9";
    case (op)
      5, 6, 7, 8, 9: return "R2";
      10:            return "R3";
      0, 2:          return "R6";
      1, 3:          return "R7";
      default:       return "R4";
    endcase
  endfunction

  // behavioural reference of R1..R11
  task automatic refModel(input int op, input int s, input int d, input bit bm,
                          input bit [3:0] f, input bit [2:0] cond,
                          output int r, output bit we, output bit [3:0] nf, output bit tk);
    int w, mask, x, a, y, cin, full, nC, nV, cy, t;
    bit keep;
    w = (bm && op != 1 && op != 3) ? 8 : 16;
    mask = (1 << w) - 1;
    x = d & mask; a = s & mask;
    keep = 0; nC = 0; nV = 0; r = 0;
    case (op)
      4: begin r = a; keep = 1; end
      5, 6, 7, 8, 9: begin
        y   = (op >= 7) ? (~a & mask) : a;
        cin = (op == 6 || op == 7) ? int'(f[0]) : ((op >= 8) ? 1 : 0);
        full = x + y + cin;
        r  = full & mask;
        nC = (full >> w) & 1;
        nV = (((x ^ r) & (y ^ r)) >> (w - 1)) & 1;
      end
      10: begin
        cy = f[0];
        for (int i = 0; i < w / 4; i++) begin
          t = ((x >> (4*i)) & 15) + ((a >> (4*i)) & 15) + cy;
          if (t > 9) begin t = t - 10; cy = 1; end else cy = 0;
          r = r | ((t & 15) << (4*i));
        end
        nC = cy;
      end
      11, 15: begin r = a & x; nC = (r != 0); end
      12: begin r = ~a & x & mask; keep = 1; end
      13: begin r = a | x; keep = 1; end
      14: begin r = a ^ x; nC = (r != 0); nV = ((a >> (w-1)) & 1) & ((x >> (w-1)) & 1); end
      0: begin r = (x >> 1) | (int'(f[0]) << (w - 1)); nC = x & 1; end
      2: begin r = (x >> 1) | (x & (1 << (w - 1))); nC = x & 1; end
      1: begin r = ((d & 255) << 8) | ((d >> 8) & 255); keep = 1; end
      default: begin r = (d & 128) ? ((d & 255) | 32'hFF00) : (d & 255); nC = (r != 0); end
    endcase
    we = !(op == 9 || op == 11);
    if (keep) nf = f;
    else nf = {nV[0], 1'(((r >> (w - 1)) & 1)), (r == 0), nC[0]};
    case (cond)
      0: tk = !f[1];
      1: tk = f[1];
      2: tk = !f[0];
      3: tk = f[0];
      4: tk = f[2];
      5: tk = (f[2] == f[3]);
      6: tk = (f[2] != f[3]);
      default: tk = 1;
    endcase
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on the falling edge, compare one full cycle later (one register stage)
  task automatic apply(input int op, input int s, input int d, input bit bm,
                       input bit [3:0] f, input bit [2:0] cond);
    int r; bit we; bit [3:0] nf; bit tk;
    refModel(op, s, d, bm, f, cond, r, we, nf, tk);
    opIn = op[3:0]; srcIn = s[15:0]; dstIn = d[15:0]; byteIn = bm; flagsIn = f; condIn = cond;
    @(negedge clk);
    check(reqOf(op, bm), $sformatf("result op=%0d", op), int'(resultOut), r);
    check("R5", $sformatf("writeEn op=%0d", op), int'(writeEnOut), int'(we));
    // R11 bit order {V,N,Z,C}; R8 for ops that keep flags
    check((op == 4 || op == 12 || op == 13 || op == 1) ? "R8" : reqOf(op, bm),
          $sformatf("flags op=%0d", op), int'(flagsOut), int'(nf));
    check("R10", $sformatf("branch cond=%0d", cond), int'(branchTakenOut), int'(tk));
  endtask

  initial begin
    rst_n = 1'b0; opIn = 4'd5; byteIn = 1'b0; srcIn = 16'h1234; dstIn = 16'h4321;
    flagsIn = 4'hF; condIn = 3'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset result", int'(resultOut), 0);
    check("R1", "reset writeEn", int'(writeEnOut), 0);
    check("R1", "reset flags", int'(flagsOut), 0);
    check("R1", "reset branch", int'(branchTakenOut), 0);
    rst_n = 1'b1;
    // R2 adder width edges
    apply(5, 16'h0001, 16'h7FFF, 0, 4'h0, 0);
    apply(5, 16'h0001, 16'hFFFF, 0, 4'h0, 1);
    apply(6, 16'h0000, 16'hFFFF, 0, 4'h1, 2);
    apply(8, 16'h1234, 16'h1234, 0, 4'h0, 3);
    apply(7, 16'h0001, 16'h0001, 0, 4'h0, 4);
    apply(9, 16'h0001, 16'h8000, 0, 4'h0, 5);
    // R9 byte mode
    apply(5, 16'hFF80, 16'hAA80, 1, 4'h0, 6);
    apply(8, 16'h0001, 16'h1280, 1, 4'h0, 0);
    // R3 decimal rippling
    apply(10, 16'h0001, 16'h0999, 0, 4'h0, 1);
    apply(10, 16'h0000, 16'h9999, 0, 4'h1, 2);
    apply(10, 16'h0001, 16'h0099, 1, 4'h0, 3);
    // R4 logic
    apply(14, 16'h8001, 16'h8001, 0, 4'h0, 4);
    apply(11, 16'h00F0, 16'h0F0F, 0, 4'hF, 5);
    apply(12, 16'hFFFF, 16'h1234, 0, 4'h5, 6);
    apply(13, 16'h0F00, 16'h00F0, 0, 4'hA, 7);
    // R6 shifts
    apply(0, 16'h0000, 16'h0002, 0, 4'h1, 0);
    apply(2, 16'h0000, 16'hF009, 0, 4'h0, 1);
    apply(0, 16'h0000, 16'h0081, 1, 4'h1, 2);
    // R7 swap and sign extend, byte select ignored
    apply(1, 16'h0000, 16'h12AB, 1, 4'h6, 3);
    apply(3, 16'h0000, 16'h3480, 1, 4'h0, 4);
    apply(3, 16'h0000, 16'hFF00, 0, 4'h0, 5);
    // R10 every code against N/V disagreement
    for (int c = 0; c < 8; c++) apply(4, 16'h0055, 16'h0000, 0, 4'b0100, c[2:0]);
    for (int c = 0; c < 8; c++) apply(4, 16'h0055, 16'h0000, 0, 4'b1011, c[2:0]);
    for (int k = 0; k < 3000; k++)
      apply(int'($urandom_range(0, 15)), int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF),
            1'($urandom), 4'($urandom), 3'($urandom));
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule